// File: doc/BRIEF.md
# Dual-bit serial target interface

This block is the target side of a serial port that carries two bits on every serial clock, on the two data lines of `d_in`. A host raises `cs_i` (active high) and clocks in a 16-bit instruction word as eight bit pairs. If the instruction is a write, eight more pairs follow and form a 16-bit data word, which goes into a small internal register file. If the instruction is a read, the block waits for the serial clock to go low, takes over the data lines through `d_oe`, and sends the addressed register back as eight pairs, one new pair on each rising serial clock.

The serial clock, chip select and data lines pass through a two-flop synchronizer into the system clock domain, and serial clock edges are found there. The serial clock period must be at least four system clock periods. Edges are seen three system clocks after they happen, so a host that samples read data on the falling serial edge sees stable data.

The controller has six states. IDLE: chip select low. CMD: collecting the instruction. WDATA: collecting write data. TURN: instruction read complete, waiting for the serial clock to go low. RDATA: driving read pairs. HOLD: word finished, waiting for chip select to drop. The transitions are:
- IDLE→CMD on chip select high.
- CMD→WDATA on the eighth rise when bit 15 is 0.
- CMD→TURN on the eighth rise when bit 15 is 1.
- WDATA→HOLD on the eighth rise, which also commits the write.
- TURN→RDATA on a falling serial edge.
- RDATA→HOLD on the eighth rise.
- Any state→IDLE on chip select low.

Top module: `duo_serial_target`

## Requirements
- R1: After reset `d_oe` is 0, `d_out` is 2'b00, and every register reads back as 0.
- R2: On each rising serial clock the block takes one pair from `d_in`. `d_in[1]` is the more significant bit, and the most significant pair comes first. The first eight pairs form the 16-bit instruction.
- R3: Instruction bit 15 = 0 selects a write, and bits 7..0 are the register address. Bits 14..8 are ignored. The next eight pairs form the data word, which is written once to that address when the eighth pair arrives.
- R4: If chip select drops before a word is complete, the partial word is discarded. No register write takes place, and the next cycle starts framing from a new instruction.
- R5: Instruction bit 15 = 1 selects a read. `d_oe` stays 0 until the instruction is complete and the serial clock has gone low, and it is 1 after that.
- R6: In the read data phase, each of eight rising serial clocks presents the next pair of the addressed register on `d_out`. The most significant pair comes first, with the higher bit on `d_out[1]`.
- R7: `d_oe` is 0 whenever chip select is low and throughout any write cycle.
- R8: A write to an address at or above DEPTH has no effect. The address is compared in full, not only its low bits. A read from such an address returns 0.
- R9: Serial clocks after a word has completed, before chip select drops, are ignored. A write commits only the first data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| cs_i | input | 1 | Chip select, active high |
| d_in | input | 2 | Data pair from the host; bit 1 is the more significant |
| d_out | output | 2 | Data pair driven during reads |
| d_oe | output | 1 | Output enable for the data lines |

## Verification
The bench builds the block with WORD_W=16, ADDR_W=8 and DEPTH=8. With that register file every entry can be written and read back in one sweep, using data patterns computed from the address and junk in the ignored instruction bits. The small depth also puts out-of-range addresses within easy reach, both 8 and 0x88, which aliases to entry 0 if only the low bits were compared. The bench also covers truncated instructions, truncated data words and surplus serial clocks.

// File: rtl/duo_pkg.sv
package duo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_TURN,
        ST_RDATA,
        ST_HOLD
    } duo_state_e;
endpackage

// File: rtl/duo_sync.sv
module duo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/duo_regfile.sv
module duo_regfile #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [DEPTH*WORD_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [WORD_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= '0;
            else if (we && waddr == ADDR_W'(g))
                r <= wdata;
        end
        assign flat[g*WORD_W +: WORD_W] = r;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == ADDR_W'(i))
                rdata = flat[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/duo_serial_target.sv
module duo_serial_target
    import duo_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_i,
    input  logic [1:0] d_in,
    output logic [1:0] d_out,
    output logic       d_oe
);
    localparam int PAIRS  = WORD_W / 2;
    localparam int CNT_W  = $clog2(PAIRS);
    localparam int RD_BIT = WORD_W - 1;
    localparam int SYNC_W = 4;

    // synchronized inputs and serial clock edges
    logic [SYNC_W-1:0] sync_bus;
    logic              cs_s, sclk_s, sclk_q, sclk_rise, sclk_fall;
    logic [1:0]        d_s;

    duo_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sclk_i, d_in}),
        .sync_o  (sync_bus)
    );

    assign cs_s   = sync_bus[3];
    assign sclk_s = sync_bus[2];
    assign d_s    = sync_bus[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;

    // controller state
    duo_state_e        st, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              last_pair;
    logic [WORD_W-1:0] rx_sr, rx_word, tx_sr, rd_data;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q, wr_en;

    assign last_pair = (cnt == CNT_W'(PAIRS - 1));
    assign rx_word   = {rx_sr[WORD_W-3:0], d_s};
    assign wr_en     = (st == ST_WDATA) && cs_s && sclk_rise && last_pair;

    duo_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (addr_q),
        .wdata (rx_word),
        .raddr (rx_word[ADDR_W-1:0]),
        .rdata (rd_data)
    );

    always_comb begin
        nxt = st;
        if (!cs_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  nxt = ST_CMD;
                ST_CMD:   if (sclk_rise && last_pair)
                              nxt = rx_word[RD_BIT] ? ST_TURN : ST_WDATA;
                ST_WDATA: if (sclk_rise && last_pair) nxt = ST_HOLD;
                ST_TURN:  if (sclk_fall) nxt = ST_RDATA;
                ST_RDATA: if (sclk_rise && last_pair) nxt = ST_HOLD;
                ST_HOLD:  nxt = ST_HOLD;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rx_sr  <= '0;
            tx_sr  <= '0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            d_out  <= 2'b00;
            d_oe   <= 1'b0;
        end else begin
            d_oe <= (nxt == ST_RDATA) || (nxt == ST_HOLD && rd_q);
            unique case (st)
                ST_CMD: if (sclk_rise) begin
                    rx_sr <= rx_word;
                    cnt   <= last_pair ? '0 : cnt + 1'b1;
                    if (last_pair) begin
                        addr_q <= rx_word[ADDR_W-1:0];
                        rd_q   <= rx_word[RD_BIT];
                        tx_sr  <= rd_data;
                    end
                end
                ST_WDATA: if (sclk_rise) begin
                    rx_sr <= rx_word;
                    cnt   <= last_pair ? '0 : cnt + 1'b1;
                end
                ST_RDATA: if (sclk_rise) begin
                    d_out <= tx_sr[WORD_W-1 -: 2];
                    tx_sr <= {tx_sr[WORD_W-3:0], 2'b00};
                    cnt   <= last_pair ? '0 : cnt + 1'b1;
                end
                default: ;
            endcase
            if (nxt == ST_IDLE) begin
                cnt   <= '0;
                rd_q  <= 1'b0;
                d_out <= 2'b00;
            end
        end
    end
endmodule

// File: rtl/duo_serial_checker.sv
module duo_serial_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       sclk_s,
    input logic       sclk_rise,
    input logic       we,
    input logic       d_oe,
    input logic [1:0] d_out
);
    // R7: chip select low releases the data lines on the next cycle
    p_oe_off_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !d_oe);

    // R7: never driving while a write commits
    p_oe_off_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !d_oe);

    // R3 / R9: a write commits as a single pulse
    p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R5: the block takes the lines only while the serial clock is low
    p_turn_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_oe) |-> !sclk_s);

    // R6: the output pair moves only on a rising serial clock
    p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !sclk_rise) |=> $stable(d_out));
endmodule

bind duo_serial_target duo_serial_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sclk_s    (sclk_s),
    .sclk_rise (sclk_rise),
    .we        (wr_en),
    .d_oe      (d_oe),
    .d_out     (d_out)
);

// File: tb/duo_serial_target_tb.sv
module duo_serial_target_tb;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs = 1'b0;
    logic [1:0] din = 2'b00;
    logic [1:0] d_out;
    logic       d_oe;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    duo_serial_target #(.WORD_W(16), .ADDR_W(8), .DEPTH(DEPTH)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .cs_i   (cs),
        .d_in   (din),
        .d_out  (d_out),
        .d_oe   (d_oe)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 16'h2F1B) ^ 16'hC35A;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] p, output logic [1:0] so, output logic soe);
        @(negedge clk) din = p;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        so  = d_out;
        soe = d_oe;
        sclk = 1'b0;
    endtask

    task automatic cs_on();
        @(negedge clk) cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off(output logic oe_after);
        repeat (4) @(negedge clk);
        cs = 1'b0;
        repeat (6) @(negedge clk);
        oe_after = d_oe;
    endtask

    task automatic host_write(input logic [15:0] instr, input logic [15:0] data,
                              input int ninstr, input int ndata, output logic oe_seen);
        logic [1:0] s;
        logic       o, oa;
        oe_seen = 1'b0;
        cs_on();
        for (int i = 0; i < ninstr; i++) begin
            pulse(instr[15 - 2*i -: 2], s, o);
            oe_seen |= o;
        end
        for (int i = 0; i < ndata; i++) begin
            pulse((i < 8) ? data[15 - 2*i -: 2] : 2'b11, s, o);
            oe_seen |= o;
        end
        cs_off(oa);
        oe_seen |= oa;
    endtask

    task automatic host_read(input logic [15:0] instr, output logic [15:0] word,
                             output logic oe_early, output logic oe_turn, output logic oe_after);
        logic [1:0] s;
        logic       o;
        oe_early = 1'b0;
        word = '0;
        cs_on();
        for (int i = 0; i < 8; i++) begin
            pulse(instr[15 - 2*i -: 2], s, o);
            oe_early |= o;
        end
        @(negedge clk) din = 2'b00;
        repeat (4) @(negedge clk);
        oe_turn = d_oe;
        for (int i = 0; i < 8; i++) begin
            pulse(2'b00, s, o);
            word = {word[13:0], s};
        end
        cs_off(oe_after);
    endtask

    function automatic logic [15:0] wr_ins(input int a);
        return {1'b0, 7'(a * 5 + 1), 8'(a)};
    endfunction

    function automatic logic [15:0] rd_ins(input int a);
        return {1'b1, 7'(a * 3 + 2), 8'(a)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] w;
        logic        e, t, a, ws;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 oe after reset", 16'(d_oe), 16'h0);
        chk("R1 dout after reset", 16'(d_out), 16'h0);

        host_read(rd_ins(3), w, e, t, a);
        chk("R1 reset contents", w, 16'h0000);

        // R2 R3: full write sweep with junk in the ignored instruction bits
        for (int k = 0; k < DEPTH; k++) begin
            host_write(wr_ins(k), pat(k), 8, 8, ws);
            chk("R7 oe during write", 16'(ws), 16'h0);
        end

        // R5 R6: full read sweep
        for (int k = 0; k < DEPTH; k++) begin
            host_read(rd_ins(k), w, e, t, a);
            chk("R6 R2 R3 read data", w, pat(k));
            chk("R5 oe before turnaround", 16'(e), 16'h0);
            chk("R5 oe after turnaround", 16'(t), 16'h1);
            chk("R7 oe after cs low", 16'(a), 16'h0);
        end

        // R8: out-of-range addresses
        host_write(wr_ins(8), 16'hFFFF, 8, 8, ws);
        host_write(16'h0088, 16'hFFFF, 8, 8, ws);
        host_read(rd_ins(0), w, e, t, a);
        chk("R8 full address compare", w, pat(0));
        host_read(rd_ins(8), w, e, t, a);
        chk("R8 read out of range", w, 16'h0000);
        host_read(16'h80FF, w, e, t, a);
        chk("R8 read addr ff", w, 16'h0000);

        // R4: truncated data word, then truncated instruction
        host_write(wr_ins(2), 16'h1234, 8, 5, ws);
        host_read(rd_ins(2), w, e, t, a);
        chk("R4 partial data discarded", w, pat(2));
        host_write(wr_ins(4), 16'h0, 3, 0, ws);
        host_read(rd_ins(4), w, e, t, a);
        chk("R4 framing restarts", w, pat(4));

        // R9: surplus clocks after a write word
        host_write(wr_ins(5), 16'hBEEF, 8, 13, ws);
        host_read(rd_ins(5), w, e, t, a);
        chk("R9 surplus clocks ignored", w, 16'hBEEF);
        host_read(rd_ins(6), w, e, t, a);
        chk("R9 neighbour untouched", w, pat(6));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule